// File: doc/BRIEF.md
# Posted-Write Timer with Split Clock Domains

This block is a 32-bit up-counting timer. Its counter logic runs on a functional clock of its own, and software reaches it over a simple synchronous register bus clocked by a separate bus clock. It can be started and stopped. It can reload itself from a load value on wrap-around, divide its tick by a power of two, and flag when the count reaches a compare value. It can also latch the count when a selected edge arrives on a capture input.

Writes to the five registers that feed the counter domain (control, counter, load, trigger, compare) cross clock domains through a toggle handshake. In posted mode the bus finishes such a write at once and sets a per-register pending bit, which drops when the value has landed. With posted mode off, the bus holds its ready line low until the crossing is done. The counter value, the captured value and the running state come back to the bus side through a continuously refreshed snapshot. Match, overflow and capture events set sticky status bits, which are gated by two separate masks onto an interrupt output and a wakeup output. The design assumes that the bus clock is faster than the functional clock.

Top module: `gpt_posted_timer`

## Requirements
- R1: After reset the interface-control register (0x40) reads 4, so bit 2, the posted-mode bit, is 1. The pending register (0x34), the status register (0x18) and the counter (0x28) read 0, and irq and wake are low.
- R2: In posted mode a write to control 0x24, counter 0x28, load 0x2C, trigger 0x30 or compare 0x38 completes with ready high in its first cycle. It sets pending bit 0, 1, 2, 3 or 4 respectively, and that bit clears by itself. A further write to a register whose pending bit is set waits with ready low.
- R3: With interface-control bit 2 cleared, a write to one of those five registers holds ready low for at least two cycles. The write completes only after its pending bit has cleared.
- R4: With the counter stopped, a counter write reads back unchanged, and a write of any value to the trigger register copies the load value into the counter.
- R5: Control bit 0 starts counting. Once it has been cleared and the pending bit has dropped, the counter no longer changes.
- R6: With control bit 1 (auto-reload) set, a tick at 0xFFFFFFFF loads the counter from the load register and sets status bit 1 (overflow).
- R7: Without auto-reload, a tick at 0xFFFFFFFF sets the counter to 0, stops the counter and sets status bit 1. Control bit 0 then reads back as 0.
- R8: With control bit 5 set, the counter advances once every 2^(r+1) functional-clock cycles, where r is control bits 4:2. With bit 5 clear it advances every cycle.
- R9: With control bit 6 set, status bit 0 (match) is set when a tick moves the counter onto the compare value. With bit 6 clear, no match is flagged.
- R10: Control bits 9:8 choose the capture edge: 01 rising, 10 falling, 11 both, 00 none. A selected edge latches the counter into the capture register (0x3C) and sets status bit 2. Edges that are not selected have no effect.
- R11: With control bit 13 set, only every second selected edge captures and sets status bit 2.
- R12: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged, and a set bit stays set until cleared.
- R13: irq is high exactly when a status bit is set together with the same bit of the interrupt-enable register (0x1C). wake does the same with the wakeup-enable register (0x20).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Register-bus clock |
| fclk | input | 1 | Functional (counting) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain |
| sel | input | 1 | Bus access request, held until ready |
| wr | input | 1 | 1 for write, 0 for read |
| addr | input | 8 | Byte address of a word register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while sel is high and wr is low |
| ready | output | 1 | Access completes on a clock edge where sel and ready are high |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wakeup request |

## Verification
A lost toggle in a write channel leaves its pending bit stuck, or clears it early. This shows at the pending register, and at ready in non-posted mode, within about a dozen bus cycles of the write. Wrong counter-domain state (run flag, prescaler phase, reload choice) shows up after a stop as a counter readback outside a tight window computed from elapsed time, or as a missing or extra overflow, match or capture status bit. Mask or status faults show on irq and wake in the very next bus cycle, so the bench compares those pins on every bus clock while their expected value is known.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int AW = 8;
  localparam int DW = 32;

  // register offsets
  localparam logic [AW-1:0] A_STAT  = 8'h18;
  localparam logic [AW-1:0] A_IEN   = 8'h1C;
  localparam logic [AW-1:0] A_WEN   = 8'h20;
  localparam logic [AW-1:0] A_CTRL  = 8'h24;
  localparam logic [AW-1:0] A_CNT   = 8'h28;
  localparam logic [AW-1:0] A_LOAD  = 8'h2C;
  localparam logic [AW-1:0] A_TRIG  = 8'h30;
  localparam logic [AW-1:0] A_PEND  = 8'h34;
  localparam logic [AW-1:0] A_MATCH = 8'h38;
  localparam logic [AW-1:0] A_CAPT  = 8'h3C;
  localparam logic [AW-1:0] A_IFC   = 8'h40;

  // crossing channels, index = pending bit
  localparam int NCH      = 5;
  localparam int CH_CTRL  = 0;
  localparam int CH_CNT   = 1;
  localparam int CH_LOAD  = 2;
  localparam int CH_TRIG  = 3;
  localparam int CH_MATCH = 4;
  localparam int CHW      = $clog2(NCH);

  // control fields
  localparam int B_RUN   = 0;
  localparam int B_AR    = 1;
  localparam int B_RAT   = 2;
  localparam int RATW    = 3;
  localparam int B_PRE   = 5;
  localparam int B_CE    = 6;
  localparam int B_EDGE  = 8;
  localparam int B_CMODE = 13;

  // status bits
  localparam int NST   = 3;
  localparam int S_MAT = 0;
  localparam int S_OVF = 1;
  localparam int S_CAP = 2;

  localparam int B_POSTED = 2;
endpackage

// File: rtl/gpt_xfer_chan.sv
module gpt_xfer_chan (
  input  logic bclk,
  input  logic brst_n,
  input  logic fclk,
  input  logic frst_n,
  input  logic issue,
  output logic pending,
  output logic apply
);
  logic       req_q, req_n;
  logic [1:0] ack_q;
  logic [2:0] rs_q;

  always_comb req_n = issue ? ~req_q : req_q;

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      req_q <= 1'b0;
      ack_q <= '0;
    end else begin
      req_q <= req_n;
      ack_q <= {ack_q[0], rs_q[2]};
    end
  end

  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) rs_q <= '0;
    else         rs_q <= {rs_q[1:0], req_q};
  end

  assign apply   = rs_q[2] ^ rs_q[1];
  assign pending = req_q ^ ack_q[1];

  // R2
  pend_rise_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    $rose(pending) |-> $past(issue));
  // R2
  issue_idle_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    issue |-> !pending);
endmodule

// File: rtl/gpt_snapshot.sv
module gpt_snapshot #(
  parameter int W = 65
) (
  input  logic         fclk,
  input  logic         frst_n,
  input  logic         bclk,
  input  logic         brst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] hold_q;
  logic         req_q;
  logic [1:0]   ack_q;
  logic [2:0]   bs_q;
  logic         take, land;

  assign take = (req_q == ack_q[1]);
  assign land = bs_q[2] ^ bs_q[1];

  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) begin
      hold_q <= '0;
      req_q  <= 1'b0;
      ack_q  <= '0;
    end else begin
      ack_q <= {ack_q[0], bs_q[2]};
      if (take) begin
        hold_q <= din;
        req_q  <= ~req_q;
      end
    end
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      bs_q <= '0;
      dout <= '0;
    end else begin
      bs_q <= {bs_q[1:0], req_q};
      if (land) dout <= hold_q;
    end
  end
endmodule

// File: rtl/gpt_core.sv
module gpt_core
  import gpt_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          fclk,
  input  logic          frst_n,
  input  logic          ctrl_ap,
  input  logic [DW-1:0] ctrl_d,
  input  logic          cnt_ap,
  input  logic [CW-1:0] cnt_d,
  input  logic          load_ap,
  input  logic [CW-1:0] load_d,
  input  logic          trig_ap,
  input  logic          match_ap,
  input  logic [CW-1:0] match_d,
  input  logic          cap_in,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cap_val,
  output logic          running,
  output logic [NST-1:0] ev_tog
);
  localparam int PW = (1 << RATW) + 1;

  logic [CW-1:0]   cnt_q, cnt_n, load_q, load_n, match_q, cap_q, cap_n;
  logic            run_q, run_n, ar_q, pre_q, ce_q, cmode_q, par_q, par_n;
  logic [RATW-1:0] rat_q;
  logic [1:0]      edge_q;
  logic [PW-1:0]   presc_q, presc_n, lim;
  logic [2:0]      cs_q;
  logic [NST-1:0]  tog_q, tog_n;
  logic            tick, wrap, hit_m, rise, fall, edge_hit, take;

  always_comb begin
    lim  = PW'((2 << rat_q) - 1);
    tick = run_q && (!pre_q || presc_q >= lim);
    if (!run_q || !pre_q || presc_q >= lim) presc_n = '0;
    else                                    presc_n = presc_q + 1'b1;

    wrap  = tick && (cnt_q == '1);
    cnt_n = cnt_q;
    run_n = run_q;
    if (tick) cnt_n = wrap ? (ar_q ? load_q : '0) : cnt_q + 1'b1;
    if (wrap && !ar_q) run_n = 1'b0;
    hit_m = tick && ce_q && (cnt_n == match_q);

    load_n = load_ap ? load_d : load_q;
    if (cnt_ap)  cnt_n = cnt_d;
    if (trig_ap) cnt_n = load_n;
    if (ctrl_ap) run_n = ctrl_d[B_RUN];

    rise     = cs_q[1] & ~cs_q[2];
    fall     = ~cs_q[1] & cs_q[2];
    edge_hit = (edge_q[0] & rise) | (edge_q[1] & fall);
    par_n    = par_q;
    take     = 1'b0;
    if (!cmode_q) begin
      par_n = 1'b0;
      take  = edge_hit;
    end else if (edge_hit) begin
      par_n = ~par_q;
      take  = par_q;
    end
    cap_n = take ? cnt_q : cap_q;

    tog_n = tog_q;
    tog_n[S_MAT] = tog_q[S_MAT] ^ hit_m;
    tog_n[S_OVF] = tog_q[S_OVF] ^ wrap;
    tog_n[S_CAP] = tog_q[S_CAP] ^ take;
  end

  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) begin
      cnt_q   <= '0;
      load_q  <= '0;
      match_q <= '0;
      cap_q   <= '0;
      run_q   <= 1'b0;
      ar_q    <= 1'b0;
      pre_q   <= 1'b0;
      ce_q    <= 1'b0;
      cmode_q <= 1'b0;
      rat_q   <= '0;
      edge_q  <= '0;
      par_q   <= 1'b0;
      presc_q <= '0;
      cs_q    <= '0;
      tog_q   <= '0;
    end else begin
      cnt_q   <= cnt_n;
      load_q  <= load_n;
      cap_q   <= cap_n;
      run_q   <= run_n;
      par_q   <= par_n;
      presc_q <= presc_n;
      cs_q    <= {cs_q[1:0], cap_in};
      tog_q   <= tog_n;
      if (match_ap) match_q <= match_d;
      if (ctrl_ap) begin
        ar_q    <= ctrl_d[B_AR];
        pre_q   <= ctrl_d[B_PRE];
        ce_q    <= ctrl_d[B_CE];
        cmode_q <= ctrl_d[B_CMODE];
        rat_q   <= ctrl_d[B_RAT +: RATW];
        edge_q  <= ctrl_d[B_EDGE +: 2];
      end
    end
  end

  assign cnt     = cnt_q;
  assign cap_val = cap_q;
  assign running = run_q;
  assign ev_tog  = tog_q;

  // R5
  halt_hold_chk: assert property (@(posedge fclk) disable iff (!frst_n)
    (!run_q && !cnt_ap && !trig_ap) |=> $stable(cnt_q));
  // R7
  oneshot_stop_chk: assert property (@(posedge fclk) disable iff (!frst_n)
    (run_q && cnt_q == '1 && !ar_q && !ctrl_ap && tick) |=> !run_q);
  // R9
  match_gate_chk: assert property (@(posedge fclk) disable iff (!frst_n)
    (tog_q[S_MAT] != $past(tog_q[S_MAT])) |-> $past(ce_q));
endmodule

// File: rtl/gpt_posted_timer.sv
module gpt_posted_timer
  import gpt_pkg::*;
(
  input  logic          bclk,
  input  logic          fclk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ready,
  input  logic          cap_in,
  output logic          irq,
  output logic          wake
);
  localparam int SNW = 2 * DW + 1;

  logic [1:0]     brs_q, frs_q;
  logic           brst_n, frst_n;
  logic           is_sync, tgt_pend, wr_acc, issued_q, issued_n;
  logic [CHW-1:0] ch;
  logic [NCH-1:0] pend, apply, issue;
  logic [DW-1:0]  ctrl_sh, cnt_sh, load_sh, match_sh;
  logic [NST-1:0] stat_q, stat_n, ie_q, we_q, ev_f, ev1_q, ev2_q, ev3_q, ev_set, clr;
  logic           posted_q;
  logic [DW-1:0]  cnt_f, cap_f, snap_cnt, snap_cap;
  logic           run_f, snap_run;
  logic [SNW-1:0] snap;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) brs_q <= '0;
    else        brs_q <= {brs_q[0], 1'b1};
  end
  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) frs_q <= '0;
    else        frs_q <= {frs_q[0], 1'b1};
  end
  assign brst_n = brs_q[1];
  assign frst_n = frs_q[1];

  always_comb begin
    is_sync = 1'b1;
    ch      = CHW'(CH_CTRL);
    case (addr)
      A_CTRL:  ch = CHW'(CH_CTRL);
      A_CNT:   ch = CHW'(CH_CNT);
      A_LOAD:  ch = CHW'(CH_LOAD);
      A_TRIG:  ch = CHW'(CH_TRIG);
      A_MATCH: ch = CHW'(CH_MATCH);
      default: is_sync = 1'b0;
    endcase
    tgt_pend = pend[ch];
  end

  // bus handshake: posted writes finish at issue, others wait for the crossing
  always_comb begin
    ready    = 1'b1;
    issue    = '0;
    issued_n = issued_q;
    if (sel && wr && is_sync) begin
      if (issued_q) begin
        ready = !tgt_pend;
        if (!tgt_pend) issued_n = 1'b0;
      end else if (tgt_pend) begin
        ready = 1'b0;
      end else begin
        issue[ch] = 1'b1;
        ready     = posted_q;
        issued_n  = !posted_q;
      end
    end
    wr_acc = sel && wr && !is_sync;
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chan
      gpt_xfer_chan u_chan (
        .bclk    (bclk),
        .brst_n  (brst_n),
        .fclk    (fclk),
        .frst_n  (frst_n),
        .issue   (issue[g]),
        .pending (pend[g]),
        .apply   (apply[g])
      );
    end
  endgenerate

  // status: set by synced event toggles, cleared by writing ones
  always_comb begin
    ev_set = ev2_q ^ ev3_q;
    clr    = (wr_acc && addr == A_STAT) ? wdata[NST-1:0] : '0;
    stat_n = (stat_q & ~clr) | ev_set;
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      issued_q <= 1'b0;
      ctrl_sh  <= '0;
      cnt_sh   <= '0;
      load_sh  <= '0;
      match_sh <= '0;
      stat_q   <= '0;
      ie_q     <= '0;
      we_q     <= '0;
      posted_q <= 1'b1;
      ev1_q    <= '0;
      ev2_q    <= '0;
      ev3_q    <= '0;
    end else begin
      issued_q <= issued_n;
      stat_q   <= stat_n;
      ev1_q    <= ev_f;
      ev2_q    <= ev1_q;
      ev3_q    <= ev2_q;
      if (issue[CH_CTRL])  ctrl_sh  <= wdata;
      if (issue[CH_CNT])   cnt_sh   <= wdata;
      if (issue[CH_LOAD])  load_sh  <= wdata;
      if (issue[CH_MATCH]) match_sh <= wdata;
      if (wr_acc && addr == A_IEN) ie_q     <= wdata[NST-1:0];
      if (wr_acc && addr == A_WEN) we_q     <= wdata[NST-1:0];
      if (wr_acc && addr == A_IFC) posted_q <= wdata[B_POSTED];
    end
  end

  gpt_core #(.CW(DW)) u_core (
    .fclk     (fclk),
    .frst_n   (frst_n),
    .ctrl_ap  (apply[CH_CTRL]),
    .ctrl_d   (ctrl_sh),
    .cnt_ap   (apply[CH_CNT]),
    .cnt_d    (cnt_sh),
    .load_ap  (apply[CH_LOAD]),
    .load_d   (load_sh),
    .trig_ap  (apply[CH_TRIG]),
    .match_ap (apply[CH_MATCH]),
    .match_d  (match_sh),
    .cap_in   (cap_in),
    .cnt      (cnt_f),
    .cap_val  (cap_f),
    .running  (run_f),
    .ev_tog   (ev_f)
  );

  gpt_snapshot #(.W(SNW)) u_snap (
    .fclk   (fclk),
    .frst_n (frst_n),
    .bclk   (bclk),
    .brst_n (brst_n),
    .din    ({run_f, cnt_f, cap_f}),
    .dout   (snap)
  );
  assign {snap_run, snap_cnt, snap_cap} = snap;

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT:  rdata = DW'(stat_q);
      A_IEN:   rdata = DW'(ie_q);
      A_WEN:   rdata = DW'(we_q);
      A_CTRL:  rdata = {ctrl_sh[DW-1:1], pend[CH_CTRL] ? ctrl_sh[B_RUN] : snap_run};
      A_CNT:   rdata = snap_cnt;
      A_LOAD:  rdata = load_sh;
      A_PEND:  rdata = DW'(pend);
      A_MATCH: rdata = match_sh;
      A_CAPT:  rdata = snap_cap;
      A_IFC:   rdata = DW'(posted_q) << B_POSTED;
      default: rdata = '0;
    endcase
  end

  assign irq  = |(stat_q & ie_q);
  assign wake = |(stat_q & we_q);

  generate
    for (g = 0; g < NST; g++) begin : g_stat_chk
      // R12
      stat_sticky_chk: assert property (@(posedge bclk) disable iff (!brst_n)
        (stat_q[g] && !(sel && wr && addr == A_STAT && wdata[g])) |=> stat_q[g]);
    end
  endgenerate

  // R3
  np_wait_chk: assert property (@(posedge bclk) disable iff (!brst_n)
    (sel && wr && is_sync && !posted_q && !issued_q) |-> !ready);
endmodule

// File: tb/gpt_posted_timer_tb.sv
`timescale 1ns/1ps
module gpt_posted_timer_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int FCLK_PERIOD = 26;

  logic        bclk = 0, fclk = 0, rst_n = 0;
  logic        sel = 0, wr = 0, cap_in = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        ready, irq, wake;

  int checks = 0, errors = 0;
  bit done = 0;
  // reference state of the bus-side masks and status
  bit         m_valid = 0;
  logic [2:0] m_stat = 0, m_ie = 0, m_we = 0;

  always #(CLK_PERIOD/2)  bclk = ~bclk;
  always #(FCLK_PERIOD/2) fclk = ~fclk;

  gpt_posted_timer u_dut (
    .bclk(bclk), .fclk(fclk), .rst_n(rst_n), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready),
    .cap_in(cap_in), .irq(irq), .wake(wake));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of irq/wake while the model status is known (R13)
  always @(negedge bclk) begin
    if (m_valid && !done) begin
      chk(irq == |(m_stat & m_ie), "R13 irq", irq, |(m_stat & m_ie));
      chk(wake == |(m_stat & m_we), "R13 wake", wake, |(m_stat & m_we));
    end
  end

  task automatic bus_wr_w(input logic [7:0] a, input logic [31:0] d, output int waits);
    @(negedge bclk);
    sel = 1; wr = 1; addr = a; wdata = d; waits = 0;
    #1;
    while (!ready) begin
      @(negedge bclk); #1; waits++;
    end
    @(posedge bclk); #1;
    sel = 0; wr = 0;
    if (a == 8'h1C) m_ie = d[2:0];
    if (a == 8'h20) m_we = d[2:0];
    if (a == 8'h18) m_stat = m_stat & ~d[2:0];
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    int w;
    bus_wr_w(a, d, w);
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge bclk);
    sel = 1; wr = 0; addr = a;
    #1; v = rdata;
    @(posedge bclk); #1;
    sel = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] p;
    int n = 0;
    bus_rd(8'h34, p);
    while (p != 0 && n < 100) begin
      bus_rd(8'h34, p); n++;
    end
    chk(p == 0, "R2 pending clears", p, 0);
    repeat (40) @(negedge bclk);
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge bclk);
  endtask

  task automatic rate_run(input logic [31:0] c, input int div, input int tol, input string tag);
    logic [31:0] v;
    longint t0, t1, e;
    bus_wr(8'h28, 0); wait_idle();
    bus_wr(8'h24, c); t0 = $time;
    wt(400);
    bus_wr(8'h24, 0); t1 = $time;
    wait_idle();
    bus_rd(8'h28, v);
    e = (t1 - t0) / (FCLK_PERIOD * div);
    chk(v + tol >= e && v <= e + tol, tag, v, e);
  endtask

  initial begin
    logic [31:0] v, v2;
    int w;
    #(3*CLK_PERIOD); rst_n = 1;
    wt(50);

    // R1 reset state
    bus_rd(8'h40, v); chk(v == 4, "R1 ifctrl", v, 4);
    bus_rd(8'h34, v); chk(v == 0, "R1 pending", v, 0);
    bus_rd(8'h18, v); chk(v == 0, "R1 status", v, 0);
    bus_rd(8'h28, v); chk(v == 0, "R1 counter", v, 0);
    chk(!irq && !wake, "R1 irq/wake", {irq, wake}, 0);

    // R2 posted write
    bus_wr_w(8'h2C, 32'h100, w); chk(w == 0, "R2 no wait", w, 0);
    bus_rd(8'h34, v); chk(v == 4, "R2 load pending bit", v, 4);
    bus_wr_w(8'h2C, 32'h100, w); chk(w > 0, "R2 stall on pending", w, 1);
    wait_idle();

    // R4 counter write and trigger
    bus_wr(8'h28, 32'h12345678); wait_idle();
    bus_rd(8'h28, v); chk(v == 32'h12345678, "R4 counter readback", v, 32'h12345678);
    bus_wr(8'h30, 32'hDEAD); wait_idle();
    bus_rd(8'h28, v); chk(v == 32'h100, "R4 trigger copies load", v, 32'h100);

    // R6 auto-reload, R5 halt
    bus_wr(8'h2C, 5); bus_wr(8'h28, 32'hFFFF_FFF0); bus_wr(8'h24, 3);
    wt(100);
    bus_wr(8'h24, 0); wait_idle();
    bus_rd(8'h18, v); chk(v == 2, "R6 overflow status", v, 2);
    bus_rd(8'h28, v); chk(v > 5 && v < 65, "R6 reloaded count", v, 5);
    wt(50);
    bus_rd(8'h28, v2); chk(v2 == v, "R5 stopped counter stable", v2, v);

    // R12 write-one-to-clear
    bus_wr(8'h18, 0); bus_rd(8'h18, v); chk(v == 2, "R12 zero write keeps", v, 2);
    bus_wr(8'h18, 2); bus_rd(8'h18, v); chk(v == 0, "R12 one clears", v, 0);

    // R7 one-shot
    bus_wr(8'h28, 32'hFFFF_FFF8); bus_wr(8'h24, 1);
    wt(100); wait_idle();
    bus_rd(8'h28, v); chk(v == 0, "R7 counter zero", v, 0);
    bus_rd(8'h24, v); chk(v == 0, "R7 start reads 0", v, 0);
    bus_rd(8'h18, v); chk(v == 2, "R7 overflow status", v, 2);

    // R13 masks
    m_stat = 3'b010; m_ie = 0; m_we = 0; m_valid = 1;
    bus_wr(8'h1C, 2); wt(2); chk(irq && !wake, "R13 irq only", {irq, wake}, 2);
    bus_wr(8'h1C, 0); bus_wr(8'h20, 2); wt(2); chk(!irq && wake, "R13 wake only", {irq, wake}, 1);
    bus_wr(8'h1C, 1); wt(2); chk(!irq, "R13 other bit masked", irq, 0);
    bus_wr(8'h18, 2); wt(2); chk(!irq && !wake, "R13 cleared", {irq, wake}, 0);
    m_valid = 0;
    bus_wr(8'h1C, 0); bus_wr(8'h20, 0);

    // R8 prescaler
    rate_run(32'h1, 1, 3, "R8 no prescaler");
    rate_run(32'h25, 4, 2, "R8 divide by 4");
    rate_run(32'h29, 8, 2, "R8 divide by 8");
    bus_wr(8'h18, 7);

    // R9 compare
    bus_wr(8'h38, 30); bus_wr(8'h28, 0); bus_wr(8'h24, 32'h41);
    wt(200); bus_wr(8'h24, 0); wait_idle();
    bus_rd(8'h18, v); chk(v[0] == 1, "R9 match set", v, 1);
    bus_wr(8'h18, 7);
    bus_wr(8'h28, 0); bus_wr(8'h24, 1);
    wt(200); bus_wr(8'h24, 0); wait_idle();
    bus_rd(8'h18, v); chk(v[0] == 0, "R9 compare disabled", v, 0);
    bus_wr(8'h18, 7);

    // R10 capture edges
    bus_wr(8'h28, 0); bus_wr(8'h24, 32'h101); wait_idle(); wt(20);
    cap_in = 1; wt(20);
    bus_rd(8'h18, v); chk(v[2] == 1, "R10 rising captured", v, 4);
    wt(40);
    bus_rd(8'h3C, v); bus_rd(8'h28, v2);
    chk(v > 0 && v < v2, "R10 capture value", v, v2);
    bus_wr(8'h18, 7);
    bus_wr(8'h24, 32'h201); wait_idle();
    cap_in = 0; wt(20);
    bus_rd(8'h18, v); chk(v[2] == 1, "R10 falling captured", v, 4);
    bus_wr(8'h18, 7);
    cap_in = 1; wt(20);
    bus_rd(8'h18, v); chk(v[2] == 0, "R10 rising ignored", v, 0);
    bus_wr(8'h24, 32'h301); wait_idle();
    cap_in = 0; wt(20);
    bus_rd(8'h18, v); chk(v[2] == 1, "R10 both: fall", v, 4);
    bus_wr(8'h18, 7);
    cap_in = 1; wt(20);
    bus_rd(8'h18, v); chk(v[2] == 1, "R10 both: rise", v, 4);
    bus_wr(8'h18, 7);
    bus_wr(8'h24, 32'h001); wait_idle();
    cap_in = 0; wt(20); cap_in = 1; wt(20);
    bus_rd(8'h18, v); chk(v[2] == 0, "R10 capture off", v, 0);

    // R11 every second edge
    bus_wr(8'h24, 32'h2101); wait_idle();
    cap_in = 0; wt(20); cap_in = 1; wt(20);
    bus_rd(8'h18, v); chk(v[2] == 0, "R11 first edge skipped", v, 0);
    cap_in = 0; wt(20); cap_in = 1; wt(20);
    bus_rd(8'h18, v); chk(v[2] == 1, "R11 second edge captured", v, 4);
    bus_wr(8'h24, 0); wait_idle(); bus_wr(8'h18, 7);

    // R3 non-posted
    bus_wr(8'h40, 0);
    bus_wr_w(8'h2C, 32'h77, w); chk(w >= 2, "R3 ready held low", w, 2);
    bus_rd(8'h34, v); chk(v == 0, "R3 no pending after", v, 0);
    bus_rd(8'h2C, v); chk(v == 32'h77, "R3 load value", v, 32'h77);
    bus_wr(8'h40, 4);
    bus_rd(8'h40, v); chk(v == 4, "R3 posted restored", v, 4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule